// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Interpolator

This block sits beside the feedback divider of a frequency synthesizer and picks the divide value for every comparison cycle of the phase detector. Every reference strobe adds a fraction word `f` to an accumulator that counts modulo a programmable `M`. When the sum reaches or passes `M`, the modulus is subtracted and the carry requests a divide of `N + 1` for that cycle. In every other cycle the divide value is `N`. Over time the divider settles on an average ratio of `N + f/M`, so the output channel step can be much finer than the comparison frequency.

Setting `f = 0` gives plain integer division. The carry pattern repeats every `M` strobes. The integer part, the fraction and the modulus are all sampled on the strobe. When a strobe arrives with a modulus that differs from the one used on the previous strobe, the accumulator restarts from zero. The divide value and the carry flag are registered and hold steady between strobes.

Top module: `fracn_interp`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, `div_val` reads 0, `ovf` reads 0 and the accumulator is zero.
- R2: `div_val` and `ovf` change only in the clock cycle after a cycle with `ref_stb` high. Changes to `int_n`, `frac_f` or `mod_m` without a strobe have no effect on the outputs.
- R3: After a strobe, `div_val` equals the `int_n` sampled with that strobe plus 1 when `ovf` is 1, and plus 0 when `ovf` is 0.
- R4: On a strobe, the sum is accumulator + `frac_f`. If the sum is at least `mod_m`, then `ovf` is 1 and the accumulator becomes sum − `mod_m`. Otherwise `ovf` is 0 and the accumulator becomes the sum. A change of `frac_f` alone keeps the accumulator.
- R5: A strobe with `frac_f = 0` never sets `ovf`.
- R6: Take any `M` consecutive strobes with constant `frac_f = f` and `mod_m = M`. Exactly `f` of them set `ovf`.
- R7: With constant settings, the `ovf` result of strobe k+M equals that of strobe k.
- R8: A strobe whose `mod_m` differs from the modulus of the previous strobe treats the accumulator as zero. The result is accumulator = `frac_f` and `ovf` = 0.
- R9: With `int_n = 450`, `frac_f = 1` and `mod_m = 10`, starting from a cleared accumulator, strobes 1 to 9 give 450 and strobe 10 gives 451, and the pattern repeats.
- R10: A change of `int_n` between strobes applies at the next strobe and does not disturb the accumulator sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_stb | input | 1 | One-cycle pulse, once per reference comparison cycle |
| int_n | input | NW | Integer divide value N |
| frac_f | input | MW | Fraction numerator f, with f < M |
| mod_m | input | MW | Modulus M, with M ≥ 2 |
| div_val | output | NW+1 | Divide value selected for the current cycle |
| ovf | output | 1 | Accumulator carry of the last strobe |

## Verification
The properties assume that every strobe presents a modulus of at least 2 and a fraction below that modulus. One property states this assumption, so a violating stimulus is flagged rather than producing a false result downstream. The bench keeps within this domain by construction. It sweeps every modulus from 2 to 12, and within each modulus every fraction from 0 to M − 1. It walks the modulus downward inside each fraction group so that consecutive settings always change the modulus, which restarts the accumulator and makes the expected carry of strobe k, counted from the restart, computable as whether floor(k·f/M) stepped.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int FRACN_NW_DEF = 16;
  localparam int FRACN_MW_DEF = 12;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_PLUS1 = 1'b1
  } ratio_sel_e;
endpackage

// File: rtl/fracn_rst_sync.sv
module fracn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/fracn_cfg_track.sv
module fracn_cfg_track #(
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [MW-1:0] mod_in,
  output logic [MW-1:0] mod_q,
  output logic          restart
);
  logic [MW-1:0] mod_d;

  always_comb begin
    restart = (mod_in != mod_q);
    mod_d   = mod_q;
    if (stb) mod_d = mod_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= '0;
    else        mod_q <= mod_d;
  end
endmodule

// File: rtl/fracn_mod_acc.sv
module fracn_mod_acc #(
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          restart,
  input  logic [MW-1:0] frac_in,
  input  logic [MW-1:0] mod_in,
  output logic          carry,
  output logic [MW-1:0] acc_q
);
  localparam int SW = MW + 1;

  logic [MW-1:0] base;
  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;
  logic [MW-1:0] acc_d;

  always_comb begin
    base    = restart ? '0 : acc_q;
    sum     = {1'b0, base} + {1'b0, frac_in};
    carry   = (sum >= {1'b0, mod_in});
    wrapped = carry ? (sum - {1'b0, mod_in}) : sum;
    acc_d   = acc_q;
    if (stb) acc_d = wrapped[MW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fracn_div_sel.sv
module fracn_div_sel
  import fracn_pkg::*;
#(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          carry,
  input  logic [NW-1:0] n_in,
  output logic [NW:0]   div_q,
  output logic          ovf_q
);
  ratio_sel_e    sel;
  logic [NW:0]   div_d;
  logic          ovf_d;

  always_comb begin
    sel   = carry ? SEL_PLUS1 : SEL_BASE;
    div_d = div_q;
    ovf_d = ovf_q;
    if (stb) begin
      ovf_d = (sel == SEL_PLUS1);
      unique case (sel)
        SEL_PLUS1: div_d = {1'b0, n_in} + {{NW{1'b0}}, 1'b1};
        default:   div_d = {1'b0, n_in};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      div_q <= div_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/fracn_interp.sv
module fracn_interp
  import fracn_pkg::*;
#(
  parameter int NW = FRACN_NW_DEF,
  parameter int MW = FRACN_MW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_stb,
  input  logic [NW-1:0] int_n,
  input  logic [MW-1:0] frac_f,
  input  logic [MW-1:0] mod_m,
  output logic [NW:0]   div_val,
  output logic          ovf
);
  logic          rst_n_i;
  logic          restart;
  logic          carry;
  logic [MW-1:0] m_q;
  logic [MW-1:0] acc_q;

  fracn_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fracn_cfg_track #(.MW(MW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .stb     (ref_stb),
    .mod_in  (mod_m),
    .mod_q   (m_q),
    .restart (restart)
  );

  fracn_mod_acc #(.MW(MW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .stb     (ref_stb),
    .restart (restart),
    .frac_in (frac_f),
    .mod_in  (mod_m),
    .carry   (carry),
    .acc_q   (acc_q)
  );

  fracn_div_sel #(.NW(NW)) u_sel (
    .clk   (clk),
    .rst_n (rst_n_i),
    .stb   (ref_stb),
    .carry (carry),
    .n_in  (int_n),
    .div_q (div_val),
    .ovf_q (ovf)
  );
endmodule

// File: rtl/fracn_interp_chk.sv
module fracn_interp_chk #(
  parameter int NW = 16,
  parameter int MW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_stb,
  input logic [NW-1:0] int_n,
  input logic [MW-1:0] frac_f,
  input logic [MW-1:0] mod_m,
  input logic [NW:0]   div_val,
  input logic          ovf,
  input logic [MW-1:0] acc_q,
  input logic [MW-1:0] m_q
);
  logic          stb_d;
  logic [MW-1:0] cf_d, cm_d;
  logic [MW-1:0] win_f, win_m;
  logic [MW:0]   win_n, win_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d <= 1'b0;
      cf_d  <= '0;
      cm_d  <= '0;
    end else begin
      stb_d <= ref_stb;
      if (ref_stb) begin
        cf_d <= frac_f;
        cm_d <= mod_m;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_f <= '0;
      win_m <= '0;
      win_n <= '0;
      win_k <= '0;
    end else if (stb_d) begin
      if (cf_d != win_f || cm_d != win_m || win_n == {1'b0, win_m}) begin
        win_f <= cf_d;
        win_m <= cm_d;
        win_n <= {{MW{1'b0}}, 1'b1};
        win_k <= {{MW{1'b0}}, ovf};
      end else begin
        win_n <= win_n + 1'b1;
        win_k <= win_k + {{MW{1'b0}}, ovf};
      end
    end
  end

  // Input domain assumed by every other property (R4)
  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> (mod_m >= 2 && frac_f < mod_m));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb |=> ($stable(div_val) && $stable(ovf)));

  p_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> (div_val == ({1'b0, $past(int_n)} + {{NW{1'b0}}, ovf})));

  p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> (acc_q < m_q));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb && frac_f == '0) |=> !ovf);

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_d && win_m != '0 && win_n == {1'b0, win_m}) |-> (win_k == {1'b0, win_f}));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb && mod_m != m_q) |=> (!ovf && acc_q == $past(frac_f)));
endmodule

bind fracn_interp fracn_interp_chk #(.NW(NW), .MW(MW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_stb (ref_stb),
  .int_n   (int_n),
  .frac_f  (frac_f),
  .mod_m   (mod_m),
  .div_val (div_val),
  .ovf     (ovf),
  .acc_q   (acc_q),
  .m_q     (m_q)
);

// File: tb/fracn_interp_tb.sv
module fracn_interp_tb;
  localparam int NW = 16;
  localparam int MW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_stb;
  logic [NW-1:0] int_n;
  logic [MW-1:0] frac_f;
  logic [MW-1:0] mod_m;
  logic [NW:0]   div_val;
  logic          ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fracn_interp #(.NW(NW), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .int_n(int_n),
    .frac_f(frac_f), .mod_m(mod_m), .div_val(div_val), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Drive one strobe on a falling edge; results are sampled one full cycle later.
  task automatic stb(input int n, input int f, input int m,
                     output int dv, output int ov);
    @(negedge clk);
    int_n   = NW'(n);
    frac_f  = MW'(f);
    mod_m   = MW'(m);
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    dv = int'(div_val);
    ov = int'(ovf);
    @(negedge clk);
  endtask

  // Check one strobe result against the expected carry (R3, R4, R10)
  task automatic chk_step(input int n, input int dv, input int ov, input int eov,
                          input string tag);
    chk(ov == eov, tag, "ovf", ov, eov);
    chk(dv == n + eov, "R3", "div_val", dv, n + eov);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int dv, ov, held_dv, held_ov;
    int hist[0:23];
    rst_n = 1'b0; ref_stb = 1'b0; int_n = '0; frac_f = '0; mod_m = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(div_val == 0, "R1", "div_val in reset", int'(div_val), 0);
    chk(ovf == 1'b0, "R1", "ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(div_val == 0 && ovf == 1'b0, "R1", "outputs after release", int'(div_val), 0);

    // R1: accumulator starts at zero -> with M=5, f=2 first carry at strobe 3
    for (int k = 1; k <= 3; k++) begin
      stb(20, 2, 5, dv, ov);
      chk_step(20, dv, ov, (k == 3) ? 1 : 0, "R1");
    end

    // R2: no strobe, inputs change, outputs held
    held_dv = dv; held_ov = ov;
    @(negedge clk);
    int_n = 16'd999; frac_f = 12'd1; mod_m = 12'd3;
    repeat (5) @(negedge clk);
    chk(int'(div_val) == held_dv, "R2", "div_val held", int'(div_val), held_dv);
    chk(int'(ovf) == held_ov, "R2", "ovf held", int'(ovf), held_ov);

    // Sweep: f outer, M descending, so every new setting changes M (restart).
    for (int f = 0; f <= 11; f++) begin
      for (int m = 12; m >= 2; m--) begin
        if (f < m) begin
          for (int k = 1; k <= 2 * m; k++) begin
            int n_k, eov;
            n_k = 100 + ((k * 37 + f * 11 + m) % 900);
            eov = ((k * f) / m != ((k - 1) * f) / m) ? 1 : 0;
            stb(n_k, f, m, dv, ov);
            chk_step(n_k, dv, ov, eov, (f == 0) ? "R5" : "R4");
            hist[k - 1] = ov;
            if (k > m)
              chk(hist[k - 1] == hist[k - 1 - m], "R7", "periodic ovf",
                  hist[k - 1], hist[k - 1 - m]);
          end
          // R6: every window of M consecutive strobes holds exactly f carries
          for (int s = 0; s + m <= 2 * m; s++) begin
            int cnt;
            cnt = 0;
            for (int j = s; j < s + m; j++) cnt += hist[j];
            chk(cnt == f, "R6", "carries in window", cnt, f);
          end
        end
      end
    end

    // R8: modulus change clears; M=7,f=3 x3 then M=8,f=3 expects 0,0,1
    for (int k = 1; k <= 3; k++) begin
      stb(50, 3, 7, dv, ov);
      chk_step(50, dv, ov, (k == 3) ? 1 : 0, "R8");
    end
    for (int k = 1; k <= 3; k++) begin
      stb(60, 3, 8, dv, ov);
      chk_step(60, dv, ov, (k == 3) ? 1 : 0, "R8");
    end
    // R4: fraction change alone keeps accumulator (acc=1): f=5,M=8 expects 0,1,1
    for (int k = 1; k <= 3; k++) begin
      stb(70, 5, 8, dv, ov);
      chk_step(70, dv, ov, (k == 1) ? 0 : 1, "R4");
    end

    // R9: N=450, f=1, M=10 -> 451 on strobes 10 and 20 only
    for (int k = 1; k <= 20; k++) begin
      stb(450, 1, 10, dv, ov);
      chk(dv == ((k % 10 == 0) ? 451 : 450), "R9", "divide value", dv,
          (k % 10 == 0) ? 451 : 450);
    end

    // R10: N changes every strobe; carry sequence for f=3,M=4 unaffected
    for (int k = 1; k <= 8; k++) begin
      int eov;
      eov = ((k * 3) / 4 != ((k - 1) * 3) / 4) ? 1 : 0;
      stb(300 + 13 * k, 3, 4, dv, ov);
      chk_step(300 + 13 * k, dv, ov, eov, "R10");
    end

    finish_up();
  end
endmodule